// File: doc/BRIEF.md
# Low-Power Mode Controller

This block owns the power-control byte of a small 8-bit microcontroller core and turns it into clock enables. Software writes the byte over a simple register port at one fixed address. Writing the halt bit stops only the CPU clock; interrupt logic, timers and the serial port keep running. Writing the sleep bit stops the oscillator and so every clock. If both bits are written as 1, sleep wins. The byte also carries a baud-doubling bit and two general-purpose flags, which software may use to tell whether an interrupt arrived while halted.

Hardware wakes the core. A pending enabled interrupt clears the halt bit and the CPU clock returns. Only the external reset pin leaves sleep. While the oscillator runs, the reset pin must stay high for two machine cycles of twelve oscillator periods before it counts. In sleep, where the real oscillator is stopped, one sampled high level is enough. A qualified reset clears the whole byte and drives the core reset output until the pin falls.

Top module: `pwr_ctrl`

## Requirements
- R1: After the synchronous system reset, the byte at address 0x87 reads 0x00, both clock enables are 1 and the core reset output is 0.
- R2: A write at address 0x87 stores bit 7 (baud doubling, also driven on its own output), bits 3 and 2 (general flags), bit 1 (sleep) and bit 0 (halt). Bits 6 to 4 always read 0. Reads at any other address return 0x00, and writes there change nothing.
- R3: With bit 0 set and bit 1 clear, the CPU clock enable is 0 and the peripheral/oscillator enable stays 1.
- R4: With bit 1 set, both enables are 0. This includes the case where bits 1 and 0 are both set.
- R5: In halt, an interrupt-pending level sampled at a clock edge clears bit 0 at that edge, which restores the CPU clock enable. Bits 7, 3 and 2 keep their values.
- R6: In sleep, the interrupt-pending input is ignored. The byte and both enables are unchanged.
- R7: In normal running, the interrupt-pending input has no effect on the byte or the enables.
- R8: Register writes are ignored while halt or sleep is in force.
- R9: While not in sleep, the reset pin qualifies only on the 24th consecutive edge at which it is sampled high. On that edge the core reset output rises and the byte clears. A pulse of 23 edges has no effect.
- R10: In sleep, a single edge with the reset pin sampled high raises the core reset output, clears the byte and restores both enables.
- R11: Once raised, the core reset output stays high while the pin stays high. It falls at the first edge that samples the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock that the controller samples on |
| sys_rst | input | 1 | Synchronous active-high system reset |
| rst_pin | input | 1 | External reset pin level, pulse-width qualified |
| irq_pend | input | 1 | An enabled interrupt is pending |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_clk_en | output | 1 | Oscillator and peripheral clock enable |
| baud_dbl | output | 1 | Baud-rate doubling bit |
| core_rst | output | 1 | Qualified reset to the core |

## Verification
Write effects, wake-ups and resets in sleep all show one edge after the edge that samples the stimulus. The read port and the enables are combinational from the stored byte, so there is no extra latency. Running-mode reset shows after the 24th sampling edge. The bench drives every input on the falling edge and samples on the next falling edge, so each result is read half a period after the rising edge that produced it. For the 24-edge rule, the bench checks the core reset output on every falling edge of the pulse. It confirms 0 up to the 23rd edge and 1 right after the 24th.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned B_DBL    = 7;
    localparam int unsigned B_GFH    = 3;
    localparam int unsigned B_GFL    = 2;
    localparam int unsigned B_SLEEP  = 1;
    localparam int unsigned B_HALT   = 0;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_HALT  = 2'd1,
        PM_SLEEP = 2'd2
    } pmode_e;

    typedef struct packed {
        logic dbl;
        logic gf_hi;
        logic gf_lo;
        logic sleep;
        logic halt;
    } pctl_t;

    function automatic pctl_t byte_to_ctl(input logic [BYTE_W-1:0] b);
        pctl_t c;
        c.dbl   = b[B_DBL];
        c.gf_hi = b[B_GFH];
        c.gf_lo = b[B_GFL];
        c.sleep = b[B_SLEEP];
        c.halt  = b[B_HALT];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] ctl_to_byte(input pctl_t c);
        logic [BYTE_W-1:0] b;
        b          = '0;
        b[B_DBL]   = c.dbl;
        b[B_GFH]   = c.gf_hi;
        b[B_GFL]   = c.gf_lo;
        b[B_SLEEP] = c.sleep;
        b[B_HALT]  = c.halt;
        return b;
    endfunction

    // sleep outranks halt when both are set
    function automatic pmode_e ctl_mode(input pctl_t c);
        if (c.sleep)     return PM_SLEEP;
        else if (c.halt) return PM_HALT;
        else             return PM_RUN;
    endfunction

endpackage

// File: rtl/pwr_rst_filter.sv
module pwr_rst_filter #(
    parameter int unsigned RST_CYCLES = 24
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic pin,
    input  logic fast,
    output logic hit,
    output logic core_rst
);
    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RST_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             core_rst_q;

    always_comb begin
        if (!pin)                 cnt_next = '0;
        else if (cnt_q == CNT_MAX) cnt_next = cnt_q;
        else                      cnt_next = cnt_q + 1'b1;
    end

    assign hit = pin && (core_rst_q || fast || (cnt_next == CNT_MAX));

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            cnt_q      <= '0;
            core_rst_q <= 1'b0;
        end else begin
            cnt_q      <= cnt_next;
            core_rst_q <= hit;
        end
    end

    assign core_rst = core_rst_q;

    // R9
    rst_width_chk: assert property (@(posedge clk) disable iff (sys_rst)
        $rose(core_rst_q) |-> ($past(fast) || $past(cnt_q) == CNT_LAST));

    // R11
    rst_hold_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (core_rst_q && pin) |=> core_rst_q);

    // R11
    rst_drop_chk: assert property (@(posedge clk) disable iff (sys_rst)
        !pin |=> !core_rst_q);

endmodule

// File: rtl/pwr_reg.sv
module pwr_reg
    import pwr_ctrl_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h87)
) (
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              irq,
    input  logic              clr,
    output logic [BYTE_W-1:0] rdata,
    output pctl_t             ctl,
    output pmode_e            mode
);
    pctl_t ctl_q;
    logic  sel;
    logic  unused_rsvd;

    assign sel         = (addr == REG_ADDR);
    assign mode        = ctl_mode(ctl_q);
    assign unused_rsvd = ^wdata[6:4];

    always_ff @(posedge clk) begin
        if (sys_rst || clr) begin
            ctl_q <= '0;
        end else if (mode == PM_RUN) begin
            if (wr && sel) ctl_q <= byte_to_ctl(wdata);
        end else if (mode == PM_HALT) begin
            if (irq) begin
                ctl_q.halt  <= 1'b0;
                ctl_q.sleep <= 1'b0;
            end
        end
    end

    assign rdata = sel ? ctl_to_byte(ctl_q) : '0;
    assign ctl   = ctl_q;

    // R1
    reg_reset_chk: assert property (@(posedge clk)
        sys_rst |=> (ctl_q == '0));

    // R5
    halt_wake_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (mode == PM_HALT && irq && !clr) |=>
        (!ctl_q.halt && ctl_q.dbl == $past(ctl_q.dbl) &&
         ctl_q.gf_hi == $past(ctl_q.gf_hi) && ctl_q.gf_lo == $past(ctl_q.gf_lo)));

    // R6
    sleep_irq_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (mode == PM_SLEEP && !clr) |=> (ctl_q == $past(ctl_q)));

    // R8
    lowpwr_wr_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (mode != PM_RUN && wr && !irq && !clr) |=> (ctl_q == $past(ctl_q)));

endmodule

// File: rtl/pwr_gate.sv
module pwr_gate
    import pwr_ctrl_pkg::*;
(
    input  pmode_e mode,
    output logic   cpu_en,
    output logic   osc_en
);
    always_comb begin
        case (mode)
            PM_HALT:  begin cpu_en = 1'b0; osc_en = 1'b1; end
            PM_SLEEP: begin cpu_en = 1'b0; osc_en = 1'b0; end
            default:  begin cpu_en = 1'b1; osc_en = 1'b1; end
        endcase
    end

    // R4
    gate_order_chk: assert final (osc_en || !cpu_en);

endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
    import pwr_ctrl_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR   = ADDR_W'(8'h87),
    parameter int unsigned       OSC_PER_MC = 12,
    parameter int unsigned       RST_MC     = 2
) (
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              rst_pin,
    input  logic              irq_pend,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cpu_clk_en,
    output logic              osc_clk_en,
    output logic              baud_dbl,
    output logic              core_rst
);
    localparam int unsigned RST_CYCLES = OSC_PER_MC * RST_MC;

    pctl_t  ctl;
    pmode_e mode;
    logic   rst_hit;

    pwr_rst_filter #(.RST_CYCLES(RST_CYCLES)) u_filt (
        .clk      (clk),
        .sys_rst  (sys_rst),
        .pin      (rst_pin),
        .fast     (mode == PM_SLEEP),
        .hit      (rst_hit),
        .core_rst (core_rst)
    );

    pwr_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk     (clk),
        .sys_rst (sys_rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .irq     (irq_pend),
        .clr     (rst_hit),
        .rdata   (bus_rdata),
        .ctl     (ctl),
        .mode    (mode)
    );

    pwr_gate u_gate (
        .mode   (mode),
        .cpu_en (cpu_clk_en),
        .osc_en (osc_clk_en)
    );

    assign baud_dbl = ctl.dbl;

endmodule

// File: tb/pwr_ctrl_tb.sv
module pwr_ctrl_tb;
    localparam time CLK_P = 8ns;

    logic       clk = 1'b0;
    logic       sys_rst = 1'b1;
    logic       rst_pin = 1'b0;
    logic       irq_pend = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h87;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cpu_clk_en, osc_clk_en, baud_dbl, core_rst;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pwr_ctrl u_dut (
        .clk(clk), .sys_rst(sys_rst), .rst_pin(rst_pin), .irq_pend(irq_pend),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_clk_en(cpu_clk_en), .osc_clk_en(osc_clk_en),
        .baud_dbl(baud_dbl), .core_rst(core_rst)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 8'h87;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h87;
    endtask

    task automatic en_chk(input string tag, input logic cpu, input logic osc);
        chk({tag, " cpu_en"}, {7'd0, cpu_clk_en}, {7'd0, cpu});
        chk({tag, " osc_en"}, {7'd0, osc_clk_en}, {7'd0, osc});
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h87, v);
        chk("R1 byte", v, 8'h00);
        en_chk("R1", 1'b1, 1'b1);
        chk("R1 core_rst", {7'd0, core_rst}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(8'h87, 8'h8C);
        rd(8'h87, v);
        chk("R2 store", v, 8'h8C);
        chk("R2 baud_dbl", {7'd0, baud_dbl}, 8'h01);
        wr(8'h87, 8'hFC);
        rd(8'h87, v);
        chk("R2 reserved zero", v, 8'h8C);
        rd(8'h88, v);
        chk("R2 other addr read", v, 8'h00);
        wr(8'h86, 8'h00);
        rd(8'h87, v);
        chk("R2 other addr write", v, 8'h8C);
        // R7: interrupt while running
        irq_pend = 1'b1;
        repeat (3) @(negedge clk);
        irq_pend = 1'b0;
        @(negedge clk);
        rd(8'h87, v);
        chk("R7 byte", v, 8'h8C);
        en_chk("R7", 1'b1, 1'b1);
    endtask

    task automatic t_halt();
        logic [7:0] v;
        wr(8'h87, 8'h8D);
        rd(8'h87, v);
        chk("R3 byte", v, 8'h8D);
        en_chk("R3", 1'b0, 1'b1);
        wr(8'h87, 8'h00);
        rd(8'h87, v);
        chk("R8 halt write", v, 8'h8D);
        irq_pend = 1'b1;
        @(negedge clk);
        irq_pend = 1'b0;
        rd(8'h87, v);
        chk("R5 wake byte", v, 8'h8C);
        en_chk("R5", 1'b1, 1'b1);
    endtask

    task automatic t_sleep();
        logic [7:0] v;
        wr(8'h87, 8'h0E);
        rd(8'h87, v);
        chk("R4 byte", v, 8'h0E);
        en_chk("R4", 1'b0, 1'b0);
        irq_pend = 1'b1;
        repeat (3) @(negedge clk);
        irq_pend = 1'b0;
        rd(8'h87, v);
        chk("R6 byte", v, 8'h0E);
        en_chk("R6", 1'b0, 1'b0);
        wr(8'h87, 8'h00);
        rd(8'h87, v);
        chk("R8 sleep write", v, 8'h0E);
        rst_pin = 1'b1;
        @(negedge clk);
        chk("R10 core_rst", {7'd0, core_rst}, 8'h01);
        rd(8'h87, v);
        chk("R10 byte", v, 8'h00);
        en_chk("R10", 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R11 hold", {7'd0, core_rst}, 8'h01);
        end
        rst_pin = 1'b0;
        @(negedge clk);
        chk("R11 drop", {7'd0, core_rst}, 8'h00);
    endtask

    task automatic t_both();
        logic [7:0] v;
        wr(8'h87, 8'h03);
        rd(8'h87, v);
        chk("R4 both byte", v, 8'h03);
        en_chk("R4 both", 1'b0, 1'b0);
        rst_pin = 1'b1;
        @(negedge clk);
        rst_pin = 1'b0;
        chk("R10 both core_rst", {7'd0, core_rst}, 8'h01);
        en_chk("R10 both", 1'b1, 1'b1);
        @(negedge clk);
        chk("R11 both drop", {7'd0, core_rst}, 8'h00);
    endtask

    task automatic t_run_reset();
        logic [7:0] v;
        wr(8'h87, 8'h8C);
        rst_pin = 1'b1;
        for (int k = 1; k <= 23; k++) begin
            @(negedge clk);
            chk("R9 short pulse", {7'd0, core_rst}, 8'h00);
        end
        rst_pin = 1'b0;
        @(negedge clk);
        chk("R9 short after", {7'd0, core_rst}, 8'h00);
        rd(8'h87, v);
        chk("R9 short byte kept", v, 8'h8C);
        rst_pin = 1'b1;
        for (int k = 1; k <= 23; k++) begin
            @(negedge clk);
            chk("R9 counting", {7'd0, core_rst}, 8'h00);
        end
        @(negedge clk);
        chk("R9 24th edge", {7'd0, core_rst}, 8'h01);
        rd(8'h87, v);
        chk("R9 byte cleared", v, 8'h00);
        repeat (2) begin
            @(negedge clk);
            chk("R11 run hold", {7'd0, core_rst}, 8'h01);
        end
        rst_pin = 1'b0;
        @(negedge clk);
        chk("R11 run drop", {7'd0, core_rst}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        sys_rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_halt();
        t_sleep();
        t_both();
        t_run_reset();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nbad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule